// File: doc/BRIEF.md
# Disk Controller Soft-Switch Decoder

This block sits between a processor bus and the rest of a floppy disk controller. It holds eight one-bit control latches that software flips by touching addresses, not by writing data. The latches drive three stepper/phase lines, a strobe line, the motor enable, the drive select and two register-select bits. A ninth bit follows a separate head-select input every clock. Every access, read or write, first updates one latch from the address. The register that the access then reaches depends on the new values of the two register-select latches and the motor latch. It is not chosen by a conventional register offset.

A read returns one of four things: the incoming data byte, a status byte, a write-handshake byte, or all ones. A write reaches either the mode register or a data-write port. Disk serialization, drive timing and the motor-off timer lie outside this block.

Top module: `swdec_top`

## Requirements
- R1: Under synchronous active-low reset, all eight latches, the head bit, `mode_q` and `dwr_en` are 0, and `rd_data` is 0xFF.
- R2: A clock edge with `rd_stb` or `wr_stb` high writes `addr[0]` into latch number `addr[3:1]`. Bit positions in `sw_state` are: 0–2 phase lines, 3 strobe, 4 motor enable, 5 drive select, 6 register-select low (RS0), 7 register-select high (RS1).
- R3: With both strobes low, no latch changes, whatever `addr` does.
- R4: A read at an odd address returns 0xFF.
- R5: A read at an even address with RS1=0 and RS0=0 after the update returns `rd_byte`, whether the motor latch is set or not.
- R6: A read at an even address with RS0=1 and RS1=0 returns a status byte built as follows. Bits [4:0] are `mode_q[4:0]`, bit 5 is the motor latch, bit 6 is 0, and bit 7 is the sense value.
- R7: The sense value equals `sense_in` when `drive_present` is 1, and reads as 1 when it is 0.
- R8: A read at an even address with RS1=1 and RS0=0 returns a handshake byte. Bits [5:0] are 1, bit 6 is `wr_state` and bit 7 is `buf_ready`.
- R9: A read at an even address with RS1=1 and RS0=1 returns 0xFF.
- R10: A write whose updated state has RS1=1, RS0=1 and motor=0 loads `wr_data` into `mode_q`. No other access changes `mode_q`.
- R11: A write whose updated state has RS1=1, RS0=1 and motor=1 raises `dwr_en` for one cycle, with `dwr_byte` equal to `wr_data`. In all other cycles `dwr_en` is 0.
- R12: `sw_state[8]` follows `head_sel` with one cycle of delay, with or without a strobe.
- R13: `rd_data` holds its value in every cycle that has no read strobe.
- R14: Register selection uses the latch state after the access's own update. For example, a read at address 0xC while RS0 is 1 clears RS0 and returns `rd_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 4 | Access address: [3:1] latch index, [0] new value |
| rd_stb | input | 1 | Read access strobe, one cycle per access |
| wr_stb | input | 1 | Write access strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| rd_byte | input | 8 | Current byte from the read deserializer |
| sense_in | input | 1 | Sense line from the selected drive |
| drive_present | input | 1 | 1 when a drive is attached |
| wr_state | input | 1 | Write-state flag for the handshake byte |
| buf_ready | input | 1 | Write-buffer-ready flag for the handshake byte |
| head_sel | input | 1 | External head-select level |
| rd_data | output | 8 | Registered read result |
| mode_q | output | 8 | Mode register |
| sw_state | output | 9 | Latches [7:0] and head bit [8] |
| dwr_en | output | 1 | One-cycle data-write pulse |
| dwr_byte | output | 8 | Byte that goes with `dwr_en` |

## Verification
All results are due one clock after the edge that samples a strobe: the latch vector, `rd_data`, `mode_q` and the `dwr_en` pulse. The head bit is due one clock after the level it copies. The bench changes inputs on the falling edge and lets one rising edge pass. It compares every output on the following falling edge, so each comparison sees exactly one registered step. In cycles with no strobe it checks that the outputs hold, and that `dwr_en` has returned to 0.

// File: rtl/swdec_pkg.sv
// Package: shared constants and types for the soft-switch decoder.
// Assumes eight address-selected latches; the order of the latch indices
// follows the address decode and must not be changed.
package swdec_pkg;
    localparam int IDX_PH0    = 0;
    localparam int IDX_PH1    = 1;
    localparam int IDX_PH2    = 2;
    localparam int IDX_STROBE = 3;
    localparam int IDX_MOTOR  = 4;
    localparam int IDX_DRIVE  = 5;
    localparam int IDX_RS0    = 6;
    localparam int IDX_RS1    = 7;
    localparam int IDX_HEAD   = 8;

    typedef enum logic [1:0] {
        SRC_DATA   = 2'b00,
        SRC_STATUS = 2'b01,
        SRC_HSHAKE = 2'b10,
        SRC_NONE   = 2'b11
    } rd_src_e;

    // Map the two register-select bits onto a read source.
    function automatic rd_src_e pick_src(input logic rs1, input logic rs0);
        return rd_src_e'({rs1, rs0});
    endfunction
endpackage

// File: rtl/swdec_latch_bank.sv
// Module: swdec_latch_bank
// Holds the address-controlled latches plus the head-select bit.
// Assumes at most one access per cycle (the two strobes are merged by the caller).
// Also exposes the post-access vector combinationally, so that register selection
// in the same cycle sees the updated state.
module swdec_latch_bank #(
    parameter int IDX_W = 3,
    localparam int N_SW = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic [IDX_W-1:0] idx,
    input  logic             val,
    input  logic             head_in,
    output logic [N_SW:0]    sw_post,
    output logic [N_SW:0]    sw_q
);
    // One latch per index, generated.
    for (genvar i = 0; i < N_SW; i++) begin : g_latch
        logic hit;
        assign hit        = acc && (idx == IDX_W'(i));
        assign sw_post[i] = hit ? val : sw_q[i];

        // Purpose: store this latch's post-access value.
        always_ff @(posedge clk) begin
            if (!rst_n) sw_q[i] <= 1'b0;
            else        sw_q[i] <= sw_post[i];
        end
    end

    assign sw_post[N_SW] = sw_q[N_SW];

    // Purpose: sample the head-select input every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_q[N_SW] <= 1'b0;
        else        sw_q[N_SW] <= head_in;
    end

    assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> (sw_q[N_SW-1:0] == $past(sw_q[N_SW-1:0])));

    assert_latch_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (sw_q[$past(idx)] == $past(val)));
endmodule

// File: rtl/swdec_read_mux.sv
// Module: swdec_read_mux
// Purely combinational read source selection for the decoder.
// Assumes sw_post already reflects the current access's latch update.
module swdec_read_mux
    import swdec_pkg::*;
#(
    parameter int N_SW = 8,
    parameter int DW   = 8
) (
    input  logic [N_SW:0] sw_post,
    input  logic          addr_odd,
    input  logic [DW-1:0] mode_q,
    input  logic [DW-1:0] rd_byte,
    input  logic          sense_in,
    input  logic          drive_present,
    input  logic          wr_state,
    input  logic          buf_ready,
    output logic [DW-1:0] rd_val
);
    logic    sense_bit;
    rd_src_e src;

    assign sense_bit = drive_present ? sense_in : 1'b1;
    assign src       = pick_src(sw_post[IDX_RS1], sw_post[IDX_RS0]);

    // Purpose: choose the byte that a read at this address returns.
    always_comb begin
        unique case (src)
            SRC_DATA:   rd_val = rd_byte;
            SRC_STATUS: rd_val = {sense_bit, 1'b0, sw_post[IDX_MOTOR], mode_q[4:0]};
            SRC_HSHAKE: rd_val = {buf_ready, wr_state, 6'h3F};
            default:    rd_val = '1;
        endcase
        if (addr_odd) rd_val = '1;
    end
endmodule

// File: rtl/swdec_mode_reg.sv
// Module: swdec_mode_reg
// Write-side decode: the mode register and the one-cycle data-write pulse.
// Assumes sw_post is the latch state after the current access.
module swdec_mode_reg
    import swdec_pkg::*;
#(
    parameter int N_SW = 8,
    parameter int DW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [N_SW:0] sw_post,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] mode_q,
    output logic          dwr_en,
    output logic [DW-1:0] dwr_byte
);
    logic wr_win;
    logic mode_ld;
    logic data_ld;

    assign wr_win  = wr_stb && sw_post[IDX_RS1] && sw_post[IDX_RS0];
    assign mode_ld = wr_win && !sw_post[IDX_MOTOR];
    assign data_ld = wr_win &&  sw_post[IDX_MOTOR];

    // Purpose: load the mode register on a mode write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_ld) mode_q <= wr_data;
    end

    // Purpose: raise a one-cycle data-write pulse with its byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dwr_en   <= 1'b0;
            dwr_byte <= '0;
        end else begin
            dwr_en <= data_ld;
            if (data_ld) dwr_byte <= wr_data;
        end
    end

    assert_mode_only_on_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(mode_q));

    assert_dwr_needs_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dwr_en |-> $past(wr_stb));
endmodule

// File: rtl/swdec_top.sv
// Module: swdec_top
// Bus-facing soft-switch decoder of a disk controller. Every access updates one
// latch from its address; the post-access latch state then routes the access.
// Assumes one-cycle strobes; if both strobes are high, the cycle counts as one access.
module swdec_top
    import swdec_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DW     = 8,
    localparam int IDX_W = ADDR_W - 1,
    localparam int N_SW  = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DW-1:0]     wr_data,
    input  logic [DW-1:0]     rd_byte,
    input  logic              sense_in,
    input  logic              drive_present,
    input  logic              wr_state,
    input  logic              buf_ready,
    input  logic              head_sel,
    output logic [DW-1:0]     rd_data,
    output logic [DW-1:0]     mode_q,
    output logic [N_SW:0]     sw_state,
    output logic              dwr_en,
    output logic [DW-1:0]     dwr_byte
);
    logic          acc;
    logic [N_SW:0] sw_post;
    logic [DW-1:0] rd_val;

    assign acc = rd_stb || wr_stb;

    swdec_latch_bank #(.IDX_W(IDX_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (acc),
        .idx     (addr[ADDR_W-1:1]),
        .val     (addr[0]),
        .head_in (head_sel),
        .sw_post (sw_post),
        .sw_q    (sw_state)
    );

    swdec_read_mux #(.N_SW(N_SW), .DW(DW)) u_rmux (
        .sw_post       (sw_post),
        .addr_odd      (addr[0]),
        .mode_q        (mode_q),
        .rd_byte       (rd_byte),
        .sense_in      (sense_in),
        .drive_present (drive_present),
        .wr_state      (wr_state),
        .buf_ready     (buf_ready),
        .rd_val        (rd_val)
    );

    swdec_mode_reg #(.N_SW(N_SW), .DW(DW)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .sw_post  (sw_post),
        .wr_data  (wr_data),
        .mode_q   (mode_q),
        .dwr_en   (dwr_en),
        .dwr_byte (dwr_byte)
    );

    // Purpose: capture the selected read byte on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '1;
        else if (rd_stb) rd_data <= rd_val;
    end

    assert_odd_read_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && addr[0]) |=> (rd_data == '1));

    assert_rd_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));

    assert_head_track_R12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sw_state[N_SW] == $past(head_sel)));
endmodule

// File: tb/swdec_top_test.sv
module swdec_top_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       rd_stb = 1'b0, wr_stb = 1'b0;
    logic [7:0] wr_data = '0, rd_byte = '0;
    logic       sense_in = 1'b0, drive_present = 1'b1;
    logic       wr_state = 1'b0, buf_ready = 1'b0, head_sel = 1'b0;
    logic [7:0] rd_data, mode_q, dwr_byte;
    logic [8:0] sw_state;
    logic       dwr_en;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [8:0] m_sw = '0;
    logic [7:0] m_mode = '0, m_rd = 8'hFF, m_dbyte = '0;
    logic       m_den = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swdec_top uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .wr_data(wr_data), .rd_byte(rd_byte), .sense_in(sense_in),
        .drive_present(drive_present), .wr_state(wr_state), .buf_ready(buf_ready),
        .head_sel(head_sel), .rd_data(rd_data), .mode_q(mode_q), .sw_state(sw_state),
        .dwr_en(dwr_en), .dwr_byte(dwr_byte)
    );

    function automatic logic [7:0] exp_read(input logic [8:0] sw, input logic odd,
                                            input logic [7:0] md);
        logic sb;
        sb = drive_present ? sense_in : 1'b1;            // R7
        if (odd) return 8'hFF;                           // R4
        case ({sw[7], sw[6]})
            2'b00:   return rd_byte;                     // R5
            2'b01:   return {sb, 1'b0, sw[4], md[4:0]};  // R6
            2'b10:   return {buf_ready, wr_state, 6'h3F}; // R8
            default: return 8'hFF;                       // R9
        endcase
    endfunction

    task automatic check8(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, model, let a posedge pass, check at next negedge.
    task automatic step(input logic rd, input logic wr, input logic [3:0] a,
                        input logic [7:0] wd, input string rreq);
        logic [8:0] post;
        rd_stb = rd; wr_stb = wr; addr = a; wr_data = wd;
        post = m_sw;
        if (rd || wr) post[a[3:1]] = a[0];
        if (rd) m_rd = exp_read(post, a[0], m_mode);
        m_den = wr && post[7] && post[6] && post[4];
        if (m_den) m_dbyte = wd;
        if (wr && post[7] && post[6] && !post[4]) m_mode = wd;
        post[8] = head_sel;
        m_sw = post;
        @(negedge clk);
        rd_stb = 1'b0; wr_stb = 1'b0;
        check8("R2 latches", sw_state, m_sw);
        check8(rreq, {1'b0, rd_data}, {1'b0, m_rd});
        check8("R10 mode", {1'b0, mode_q}, {1'b0, m_mode});
        check8("R11 dwr_en", {8'b0, dwr_en}, {8'b0, m_den});
        if (m_den) check8("R11 dwr_byte", {1'b0, dwr_byte}, {1'b0, m_dbyte});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        head_sel = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check8("R1 latches", sw_state, 9'h000);
        check8("R1 mode", {1'b0, mode_q}, 9'h000);
        check8("R1 rd_data", {1'b0, rd_data}, 9'h0FF);
        check8("R1 dwr_en", {8'b0, dwr_en}, 9'h000);
        rst_n = 1'b1;
        head_sel = 1'b0;
        step(1'b0, 1'b0, 4'h0, 8'h00, "R13 hold");

        // R12: head bit follows input without strobes
        head_sel = 1'b1;
        step(1'b0, 1'b0, 4'h3, 8'h00, "R13 hold");
        check8("R12 head", {8'b0, sw_state[8]}, 9'h001);
        head_sel = 1'b0;

        // R3: address changes without a strobe leave latches alone
        step(1'b0, 1'b0, 4'hF, 8'h00, "R13 hold");
        step(1'b0, 1'b0, 4'hD, 8'h00, "R3 hold");

        // R10: mode write (RS0, RS1 set, motor clear)
        step(1'b1, 1'b0, 4'hD, 8'h00, "R4 odd");
        step(1'b0, 1'b1, 4'hF, 8'h9B, "R13 hold");
        check8("R10 mode loaded", {1'b0, mode_q}, 9'h09B);

        // R9: RS1=RS0=1 even read gives ones
        rd_byte = 8'h12;
        step(1'b1, 1'b0, 4'h8, 8'h00, "R9 none");
        check8("R9 ones", {1'b0, rd_data}, 9'h0FF);

        // R11: data write with motor set
        step(1'b1, 1'b0, 4'h9, 8'h00, "R4 odd");
        step(1'b0, 1'b1, 4'hF, 8'h5A, "R13 hold");
        check8("R11 pulse", {8'b0, dwr_en}, 9'h001);
        step(1'b0, 1'b0, 4'h0, 8'h00, "R13 hold");
        check8("R11 pulse end", {8'b0, dwr_en}, 9'h000);

        // R14 + R5: read at 0xE clears RS1 -> RS0 only -> status; R7 sense forced
        drive_present = 1'b0; sense_in = 1'b0;
        step(1'b1, 1'b0, 4'hE, 8'h00, "R6 status");
        check8("R7 sense absent", {8'b0, rd_data[7]}, 9'h001);
        check8("R6 status low bits", {4'b0, rd_data[4:0]}, 9'h01B);
        drive_present = 1'b1;
        rd_byte = 8'hC3;
        step(1'b1, 1'b0, 4'hC, 8'h00, "R14 post-access");
        check8("R14 data after clear", {1'b0, rd_data}, 9'h0C3);

        // R8: handshake
        wr_state = 1'b1; buf_ready = 1'b0;
        step(1'b1, 1'b0, 4'hF, 8'h00, "R4 odd");
        step(1'b1, 1'b0, 4'h2, 8'h00, "R8 handshake");
        check8("R8 handshake", {1'b0, rd_data}, 9'h07F);

        // Random traffic
        for (int k = 0; k < 3000; k++) begin
            logic [1:0] op;
            op = 2'($urandom_range(0, 3));
            rd_byte       = 8'($urandom);
            sense_in      = 1'($urandom);
            drive_present = 1'($urandom);
            wr_state      = 1'($urandom);
            buf_ready     = 1'($urandom);
            head_sel      = 1'($urandom);
            step(op == 2'd1 || op == 2'd3, op == 2'd2, 4'($urandom), 8'($urandom),
                 "R5 R6 R8 R9 read");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule